// File: doc/BRIEF.md
# Truncating Binary32 Multiplier

This block multiplies two IEEE binary32 operands and registers a binary32 product, together with an overflow flag and an underflow flag, on the rising clock edge. The result sign, the biased exponent sum and the full 24×24 significand product are formed combinationally in a single cycle. The normalized fraction is then cut to 23 bits. No rounding is applied.

A classifier looks at both operands and at the normalized exponent. It tells the datapath which result to pick: the arithmetic product, signed zero, signed infinity or a fixed quiet NaN. It also tells the datapath which flag to raise. Subnormal operands are read as zero. The block is meant to feed a wider arithmetic unit that needs a cheap multiply with explicit range flags and can live with truncated results.

Top module: `fmul_trunc`

## Requirements
- R1: While `rstN` is low, `prod`, `ovfFlag` and `unfFlag` are all zero, whatever the operands are.
- R2: `prod` is packed as sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. For every non-NaN result, its sign bit is the XOR of the two operand sign bits. Outputs reflect the operands sampled at the previous rising edge.
- R3: The result exponent is expA + expB − 127. When bit 47 of the 48-bit significand product is set, the fraction is product bits 46:24 and the exponent is incremented by one. Otherwise the fraction is bits 45:23.
- R4: Product bits below the kept fraction are discarded without rounding, even when they exceed half an ulp.
- R5: When the normalized biased exponent is greater than 254, `ovfFlag` is 1 and `prod` is infinity (exponent 255, fraction 0) with the computed sign.
- R6: When the normalized biased exponent is less than 1, including strongly negative sums, `unfFlag` is 1 and `prod` is zero with the computed sign.
- R7: Normalized exponents of exactly 1 and exactly 254 give an ordinary product with both flags low. This includes a case where the increment from bit 47 lifts a sum of 0 up to 1.
- R8: An operand with exponent field 0 (zero or subnormal) gives signed zero with both flags low, provided the other operand is not NaN or infinity.
- R9: A NaN operand (exponent 255, fraction nonzero), or infinity times zero, gives 0x7FC00000 with both flags low.
- R10: Infinity times a finite nonzero operand gives infinity with the XOR sign and both flags low.
- R11: `ovfFlag` and `unfFlag` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 32 | First binary32 operand |
| opB | input | 32 | Second binary32 operand |
| prod | output | 32 | Registered binary32 product |
| ovfFlag | output | 1 | Registered overflow indication |
| unfFlag | output | 1 | Registered underflow indication |

## Verification
The bench builds the block with its default field widths: an 8-bit exponent and a 23-bit fraction. These widths make the hand-computed binary32 corner cases reachable. They include the exact limits 1 and 254, an exponent sum that reaches 381, and one that falls to −125, which only the 10-bit signed exponent path resolves. They also include a product whose discarded tail exceeds half an ulp, so rounding and truncation give different answers. Special operands are paired with zero, finite and infinite partners to exercise every branch of the selection priority.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  typedef struct packed {
    logic pickNan;
    logic pickZero;
    logic pickInf;
    logic raiseOvf;
    logic raiseUnf;
  } fmulStrobe_t;
endpackage

// File: rtl/fmul_ctrl.sv
module fmul_ctrl
  import fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int XW    = EXP_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [EXP_W-1:0]     expA,
  input  logic [EXP_W-1:0]     expB,
  input  logic                 fracNzA,
  input  logic                 fracNzB,
  input  logic signed [XW-1:0] expNorm,
  output fmulStrobe_t          stb
);
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic signed [XW-1:0] EHI = XW'(EMAX - 1);
  localparam logic signed [XW-1:0] ELO = XW'(1);

  logic zA, zB, infA, infB, nanA, nanB, finite;

  always_comb begin
    zA   = (expA == '0);
    zB   = (expB == '0);
    infA = (expA == EXP_W'(EMAX)) && !fracNzA;
    infB = (expB == EXP_W'(EMAX)) && !fracNzB;
    nanA = (expA == EXP_W'(EMAX)) && fracNzA;
    nanB = (expB == EXP_W'(EMAX)) && fracNzB;

    stb.pickNan  = nanA || nanB || (infA && zB) || (infB && zA);
    stb.pickZero = !stb.pickNan && (zA || zB);
    stb.pickInf  = !stb.pickNan && !stb.pickZero && (infA || infB);
    finite       = !stb.pickNan && !stb.pickZero && !stb.pickInf;
    stb.raiseOvf = finite && (expNorm > EHI);
    stb.raiseUnf = finite && (expNorm < ELO);
  end

  // R8
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((zA || zB) && !stb.pickNan && !infA && !infB) |-> (!stb.raiseOvf && !stb.raiseUnf));

  // R9
  nan_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pickNan |-> !stb.pickZero && !stb.pickInf && !stb.raiseOvf && !stb.raiseUnf);

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.pickNan, stb.pickZero, stb.pickInf, stb.raiseOvf, stb.raiseUnf}));
endmodule

// File: rtl/fmul_dp.sv
module fmul_dp
  import fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int XW     = EXP_W + 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WORD_W-1:0]     opA,
  input  logic [WORD_W-1:0]     opB,
  input  fmulStrobe_t           stb,
  output logic signed [XW-1:0]  expNorm,
  output logic [WORD_W-1:0]     prodQ,
  output logic                  ovfQ,
  output logic                  unfQ
);
  localparam int MW   = FRAC_W + 1;
  localparam int PW   = 2 * MW;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [XW-1:0] BIAS_S = XW'(BIAS);
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [PW-1:0]     sigProd;
  logic              hiBit;
  logic [FRAC_W-1:0] fracKeep;
  logic              signRes;
  logic [WORD_W-1:0] resNext;

  always_comb begin
    sigProd  = PW'({1'b1, opA[FRAC_W-1:0]}) * PW'({1'b1, opB[FRAC_W-1:0]});
    hiBit    = sigProd[PW-1];
    fracKeep = hiBit ? sigProd[PW-2 -: FRAC_W] : sigProd[PW-3 -: FRAC_W];
    expNorm  = $signed({2'b00, opA[WORD_W-2 -: EXP_W]})
             + $signed({2'b00, opB[WORD_W-2 -: EXP_W]})
             - BIAS_S
             + $signed({{(XW-1){1'b0}}, hiBit});
    signRes  = opA[WORD_W-1] ^ opB[WORD_W-1];

    if (stb.pickNan)
      resNext = QNAN;
    else if (stb.pickZero || stb.raiseUnf)
      resNext = {signRes, {(WORD_W-1){1'b0}}};
    else if (stb.pickInf || stb.raiseOvf)
      resNext = {signRes, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      resNext = {signRes, expNorm[EXP_W-1:0], fracKeep};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ <= '0;
      ovfQ  <= 1'b0;
      unfQ  <= 1'b0;
    end else begin
      prodQ <= resNext;
      ovfQ  <= stb.raiseOvf;
      unfQ  <= stb.raiseUnf;
    end
  end

  // R2
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.pickNan |=> prodQ[WORD_W-1] == $past(opA[WORD_W-1] ^ opB[WORD_W-1]));

  // R5
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |-> prodQ[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

  // R6
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfQ |-> prodQ[WORD_W-2:0] == '0);

  // R11
  no_dual_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfQ && unfQ));
endmodule

// File: rtl/fmul_trunc.sv
module fmul_trunc
  import fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int XW     = EXP_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] prod,
  output logic              ovfFlag,
  output logic              unfFlag
);
  fmulStrobe_t          stb;
  logic signed [XW-1:0] expNorm;

  fmul_ctrl #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .expA    (opA[WORD_W-2 -: EXP_W]),
    .expB    (opB[WORD_W-2 -: EXP_W]),
    .fracNzA (|opA[FRAC_W-1:0]),
    .fracNzB (|opB[FRAC_W-1:0]),
    .expNorm (expNorm),
    .stb     (stb)
  );

  fmul_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .stb     (stb),
    .expNorm (expNorm),
    .prodQ   (prod),
    .ovfQ    (ovfFlag),
    .unfQ    (unfFlag)
  );
endmodule

// File: tb/fmul_trunc_tb.sv
`timescale 1ns/1ps
module fmul_trunc_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] prod;
  logic        ovfFlag, unfFlag;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fmul_trunc u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .prod(prod), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  task automatic check(input string req, input logic [31:0] ep,
                       input logic eo, input logic eu);
    total++;
    if (prod !== ep || ovfFlag !== eo || unfFlag !== eu) begin
      bad++;
      $display("FAIL %s: got prod=%08h ovf=%0b unf=%0b expected prod=%08h ovf=%0b unf=%0b",
               req, prod, ovfFlag, unfFlag, ep, eo, eu);
    end
  endtask

  // drive at a falling edge, let one rising edge register, sample at next falling edge
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input string req,
                       input logic [31:0] ep, input logic eo, input logic eu);
    @(negedge clk);
    opA = a; opB = b;
    @(negedge clk);
    check(req, ep, eo, eu);
  endtask

  task automatic test_reset();
    opA = 32'h3FC00000; opB = 32'h40000000;
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic test_basic();
    apply(32'h3FC00000, 32'h40000000, "R2 R3 1.5*2", 32'h40400000, 0, 0);
    apply(32'hC0000000, 32'h40400000, "R2 -2*3", 32'hC0C00000, 0, 0);
    apply(32'hBF800000, 32'hBF800000, "R2 -1*-1", 32'h3F800000, 0, 0);
    apply(32'h3FC00000, 32'h3FC00000, "R3 bit47 1.5*1.5", 32'h40100000, 0, 0);
  endtask

  task automatic test_trunc();
    apply(32'h3FC00001, 32'h3FC00001, "R4 tail above half", 32'h40100001, 0, 0);
  endtask

  task automatic test_overflow();
    apply(32'h7F000000, 32'h40000000, "R5 ovf pos", 32'h7F800000, 1, 0);
    apply(32'hFF000000, 32'h40000000, "R5 ovf neg", 32'hFF800000, 1, 0);
    apply(32'h7F7FFFFF, 32'h7F7FFFFF, "R5 R11 ovf large", 32'h7F800000, 1, 0);
  endtask

  task automatic test_underflow();
    apply(32'h00800000, 32'h3F000000, "R6 unf pos", 32'h00000000, 0, 1);
    apply(32'h80800000, 32'h3F000000, "R6 unf neg", 32'h80000000, 0, 1);
    apply(32'h00800000, 32'h00800000, "R6 R11 unf deep", 32'h00000000, 0, 1);
  endtask

  task automatic test_limits();
    apply(32'h7E800000, 32'h40000000, "R7 exp 254", 32'h7F000000, 0, 0);
    apply(32'h00800000, 32'h3F800000, "R7 exp 1", 32'h00800000, 0, 0);
    apply(32'h00C00000, 32'h3F400000, "R7 bit47 lifts to 1", 32'h00900000, 0, 0);
  endtask

  task automatic test_zero();
    apply(32'h00000000, 32'hC0000000, "R8 zero signed", 32'h80000000, 0, 0);
    apply(32'h00000001, 32'h40000000, "R8 subnormal", 32'h00000000, 0, 0);
  endtask

  task automatic test_special();
    apply(32'h7FC00001, 32'h3F800000, "R9 nan in", 32'h7FC00000, 0, 0);
    apply(32'h7F800000, 32'h80000000, "R9 inf*zero", 32'h7FC00000, 0, 0);
    apply(32'h7F800000, 32'hC0000000, "R10 inf*-2", 32'hFF800000, 0, 0);
    apply(32'h3F000000, 32'hFF800000, "R10 0.5*-inf", 32'hFF800000, 0, 0);
  endtask

  initial begin
    test_reset();
    test_basic();
    test_trunc();
    test_overflow();
    test_underflow();
    test_limits();
    test_zero();
    test_special();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule